// File: doc/BRIEF.md
# Host Command Mailbox

The block is a small byte-addressed register window that a host uses to give commands to a device engine. The host first confirms that the command register reads zero. It then fills four parameter bytes and writes the opcode last. That final write starts execution and also acts as the busy flag. While a command is pending, the engine consumes the parameters. After a fixed number of cycles it updates the error status and returns the command register to zero. The host polls the command register until it reads zero, then reads the error status.

The block recognises one opcode. This opcode loads a pair of 16-bit bounds, base and top, for a delay buffer. Both bounds must sit on 8-byte granules. The block checks the bounds and latches them only while the device is in the operating mode that uses the buffer. In any other mode the command completes quietly and changes nothing.

Top module: `cmd_mailbox`

## Requirements
- R1: After reset every register reads 0x00, and `base_o` and `top_o` are both 0x0000.
- R2: The register map is: command at 0x0, parameter bytes 0 to 3 at 0x1 to 0x4 (read back as written), and error status at 0x8. The error status is read-only. Every other address reads 0x00, and writes to it are ignored.
- R3: While idle, a nonzero write to 0x0 starts a command. The command register then reads the opcode and the error status reads 0x00. A zero write to 0x0 while idle starts nothing.
- R4: At completion, an opcode other than 0x22 sets error bit 3 (0x08). Only one error bit is ever set, and bits other than 3 and 4 are always 0.
- R5: Opcode 0x22 with legal parameters and `buf_mode`=1 sets `base_o` to {param1,param0} and `top_o` to {param3,param2} at completion. The error status reads 0x00 afterwards. The bounds change at no other time.
- R6: Opcode 0x22 with `buf_mode`=1 sets error bit 4 (0x10) and leaves the bounds unchanged if any of these holds: base is not a multiple of 8, top+1 is not a multiple of 8, or top is not above base.
- R7: The command register stays nonzero for exactly EXEC_CYCLES clock cycles after the opcode write, then reads 0x00.
- R8: Writes to the command or parameter registers while a command is pending are ignored.
- R9: Opcode 0x22 issued with `buf_mode`=0 completes with error status 0x00 and leaves the bounds unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Host write strobe |
| addr | input | ADDR_W | Host register address |
| wr_data | input | 8 | Host write data |
| rd_data | output | 8 | Read data for `addr` (combinational) |
| buf_mode | input | 1 | Device is in the mode that uses the delay buffer |
| base_o | output | 16 | Latched buffer base bound |
| top_o | output | 16 | Latched buffer top bound |

## Verification
The assertions check these on every cycle:
- A start clears the error status.
- A zero opcode starts nothing.
- The parameters stay frozen while a command is pending.
- The error status never has more than one bit set.
- The bounds move only at completion, and only to legal values.
- The pending window never exceeds EXEC_CYCLES.

Only the bench scenarios can show the rest:
- The window is not shorter than EXEC_CYCLES.
- Each kind of illegal bound is rejected.
- The mode gate works.
- Pending writes are truly ignored, as seen in the read-back and in the bounds that finally load.

// File: rtl/cmd_mailbox.sv
module cmd_mailbox #(
  parameter int          EXEC_CYCLES = 4,
  parameter int          ADDR_W      = 4,
  parameter logic [7:0]  OP_BOUNDS   = 8'h22
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wr_data,
  output logic [7:0]        rd_data,
  input  logic              buf_mode,
  output logic [15:0]       base_o,
  output logic [15:0]       top_o
);
  localparam int         CNT_W   = $clog2(EXEC_CYCLES + 1);
  localparam logic [7:0] ERR_OPC = 8'h08;
  localparam logic [7:0] ERR_PRM = 8'h10;

  logic [7:0]       cmd_q, err_q;
  logic [3:0][7:0]  prm_q;
  logic [CNT_W-1:0] cnt_q;
  logic [15:0]      base_q, top_q;

  wire        idle     = (cmd_q == 8'h00);
  wire        host_wr  = wr_en && idle;
  wire        start    = host_wr && (addr == '0) && (wr_data != 8'h00);
  wire        done     = !idle && (cnt_q == '0);
  wire [15:0] new_base = {prm_q[1], prm_q[0]};
  wire [15:0] new_top  = {prm_q[3], prm_q[2]};
  wire        prm_ok   = (new_base[2:0] == 3'b000) && (new_top[2:0] == 3'b111) &&
                         (new_top > new_base);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q  <= '0;
      err_q  <= '0;
      cnt_q  <= '0;
      base_q <= '0;
      top_q  <= '0;
    end else if (start) begin
      cmd_q <= wr_data;
      err_q <= '0;
      cnt_q <= CNT_W'(EXEC_CYCLES - 1);
    end else if (done) begin
      cmd_q <= '0;
      if (cmd_q != OP_BOUNDS) begin
        err_q <= ERR_OPC;
      end else if (buf_mode) begin
        if (prm_ok) begin
          base_q <= new_base;
          top_q  <= new_top;
        end else begin
          err_q <= ERR_PRM;
        end
      end
    end else if (!idle) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prm_q <= '0;
    end else begin
      for (int i = 0; i < 4; i++)
        if (host_wr && addr == ADDR_W'(i + 1)) prm_q[i] <= wr_data;
    end
  end

  always_comb begin
    case (addr)
      ADDR_W'(0): rd_data = cmd_q;
      ADDR_W'(1): rd_data = prm_q[0];
      ADDR_W'(2): rd_data = prm_q[1];
      ADDR_W'(3): rd_data = prm_q[2];
      ADDR_W'(4): rd_data = prm_q[3];
      ADDR_W'(8): rd_data = err_q;
      default:    rd_data = 8'h00;
    endcase
  end

  assign base_o = base_q;
  assign top_o  = top_q;
endmodule

// File: rtl/cmd_mailbox_chk.sv
module cmd_mailbox_chk #(
  parameter int EXEC_CYCLES = 4,
  parameter int ADDR_W      = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [7:0]        wr_data,
  input logic [7:0]        cmd_q,
  input logic [7:0]        err_q,
  input logic [3:0][7:0]   prm_q,
  input logic [15:0]       base_q,
  input logic [15:0]       top_q
);
  int pend_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              pend_cnt <= 0;
    else if (cmd_q != 8'h00) pend_cnt <= pend_cnt + 1;
    else                     pend_cnt <= 0;
  end

  AST_START_CLEARS_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q == 8'h00 && wr_en && addr == '0 && wr_data != 8'h00) |=>
      (err_q == 8'h00 && cmd_q == $past(wr_data))); // R3
  AST_ZERO_OPCODE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q == 8'h00 && wr_en && addr == '0 && wr_data == 8'h00) |=> (cmd_q == 8'h00)); // R3
  AST_PARAMS_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q != 8'h00) |=> $stable(prm_q)); // R8
  AST_ERR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(err_q) <= 1) && ((err_q & 8'hE7) == 8'h00)); // R4
  AST_BOUNDS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q == 8'h00) |=> ($stable(base_q) && $stable(top_q))); // R5
  AST_BOUNDS_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(base_q) || !$stable(top_q)) |->
      (base_q[2:0] == 3'b000 && top_q[2:0] == 3'b111 && top_q > base_q)); // R6
  AST_EXEC_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q != 8'h00) |-> (pend_cnt < EXEC_CYCLES)); // R7
endmodule

bind cmd_mailbox cmd_mailbox_chk #(.EXEC_CYCLES(EXEC_CYCLES), .ADDR_W(ADDR_W)) chk_i (.*);

// File: tb/cmd_mailbox_tb_top.sv
module cmd_mailbox_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int EXEC       = 4;
  localparam int AW         = 4;

  typedef struct packed {
    logic        mode;
    logic [15:0] base;
    logic [15:0] top;
    logic [7:0]  exp_err;
    logic [15:0] exp_base;
    logic [15:0] exp_top;
  } vec_t;

  localparam vec_t VEC [7] = '{
    '{1'b1, 16'h1000, 16'h1D1F, 8'h00, 16'h1000, 16'h1D1F},
    '{1'b1, 16'h1004, 16'h1D1F, 8'h10, 16'h1000, 16'h1D1F},
    '{1'b1, 16'h2000, 16'h2FFE, 8'h10, 16'h1000, 16'h1D1F},
    '{1'b1, 16'h3000, 16'h2FFF, 8'h10, 16'h1000, 16'h1D1F},
    '{1'b1, 16'h0008, 16'h000F, 8'h00, 16'h0008, 16'h000F},
    '{1'b0, 16'h4000, 16'h4FFF, 8'h00, 16'h0008, 16'h000F},
    '{1'b1, 16'h0000, 16'hFFFF, 8'h00, 16'h0000, 16'hFFFF}
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [7:0]    wr_data = '0;
  logic [7:0]    rd_data;
  logic          buf_mode = 1'b0;
  logic [15:0]   base_o, top_o;
  int            n_checks = 0;
  int            n_errors = 0;
  logic [7:0]    rv;

  always #(CLK_PERIOD / 2) clk = ~clk;

  cmd_mailbox #(.EXEC_CYCLES(EXEC), .ADDR_W(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .rd_data(rd_data), .buf_mode(buf_mode), .base_o(base_o), .top_o(top_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [7:0] d);
    addr = a;
    #1;
    d = rd_data;
  endtask

  task automatic wait_idle();
    int n = 0;
    rd(0, rv);
    while (rv != 8'h00 && n < 100) begin
      @(negedge clk);
      rd(0, rv);
      n++;
    end
    if (n >= 100) check("R7 poll timeout", 1, 0);
  endtask

  task automatic load(input logic [15:0] b, input logic [15:0] t, input logic [7:0] op);
    wr(1, b[7:0]); wr(2, b[15:8]); wr(3, t[7:0]); wr(4, t[15:8]);
    wr(0, op);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    check("watchdog", 1, 0);
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rd(0, rv); check("R1 cmd", rv, 0);
    rd(8, rv); check("R1 err", rv, 0);
    check("R1 base", base_o, 0);
    check("R1 top", top_o, 0);
    rst_n = 1'b1;

    for (int i = 0; i < 7; i++) begin
      buf_mode = VEC[i].mode;
      load(VEC[i].base, VEC[i].top, 8'h22);
      wait_idle();
      rd(8, rv);
      check(VEC[i].exp_err == 8'h10 ? "R6 err" : (VEC[i].mode ? "R5 err" : "R9 err"),
            rv, VEC[i].exp_err);
      check(VEC[i].mode ? "R5/R6 base" : "R9 base", base_o, VEC[i].exp_base);
      check(VEC[i].mode ? "R5/R6 top" : "R9 top", top_o, VEC[i].exp_top);
    end

    buf_mode = 1'b1;
    wr(1, 8'hA5); rd(1, rv); check("R2 param0 readback", rv, 8'hA5);
    wr(4, 8'h3C); rd(4, rv); check("R2 param3 readback", rv, 8'h3C);
    wr(5, 8'h77); rd(5, rv); check("R2 unmapped", rv, 0);
    wr(8, 8'h10); rd(8, rv); check("R2 err read-only", rv, 0);

    wr(0, 8'h15);
    rd(0, rv); check("R3 opcode visible", rv, 8'h15);
    wait_idle();
    rd(8, rv); check("R4 bad opcode", rv, 8'h08);
    check("R4 bounds kept", base_o, 16'h0000);

    wr(0, 8'h00);
    rd(0, rv); check("R3 zero write idle", rv, 0);
    rd(8, rv); check("R3 err untouched", rv, 8'h08);

    load(16'h0100, 16'h01FF, 8'h22);
    rd(8, rv); check("R3 err cleared at start", rv, 0);
    for (int k = 0; k < EXEC - 1; k++) @(negedge clk);
    rd(0, rv); check("R7 still pending", rv, 8'h22);
    @(negedge clk);
    rd(0, rv); check("R7 cleared", rv, 0);
    check("R5 base", base_o, 16'h0100);
    check("R5 top", top_o, 16'h01FF);

    load(16'h0200, 16'h02FF, 8'h22);
    @(negedge clk); addr = 1; wr_data = 8'h44; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
    rd(1, rv); check("R8 param ignored", rv, 8'h00);
    @(negedge clk); addr = 0; wr_data = 8'h15; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
    rd(0, rv); check("R8 cmd ignored", rv, 0);
    rd(8, rv); check("R8 err", rv, 0);
    check("R8 base", base_o, 16'h0200);

    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule